// File: doc/BRIEF.md
# Iterative 32x32 Integer Multiplier with Long Multiply-Accumulate

This block performs the integer multiply group of a small processor core. A 3-bit sub-opcode picks one of five operations. Two of them give a 32-bit result: a plain multiply, and a multiply that adds one accumulator word. Three of them give a 64-bit result: an unsigned long multiply, a signed long multiply, and an unsigned long multiply that adds the 64-bit value held in two accumulator words. The core reads the source and accumulator registers, pulses `start_i` for one cycle, and waits for `done_o`. On that cycle it writes back each result word whose write enable is high, and it updates N and Z when `flag_upd_o` is high.

The product is built over several cycles by a shift-and-add datapath that retires `STEP_BITS` multiplier bits per cycle. With the defaults that is 16 steps. A signed product is formed from operand magnitudes and negated at the end if needed. A finishing stage applies the sign, adds the accumulator and derives the flags. The unit has no carry or overflow output, so the caller's C and V flags are never touched. A sub-opcode that is not implemented completes after one busy cycle, raises `unsup_o` and writes nothing.

Top module: `imul_core`

## Requirements
- R1: Sub-opcode 0 writes the low 32 bits of `src_a_i*src_b_i` to `res_lo_o` with `wr_lo_o`=1 and `wr_hi_o`=0. The accumulator inputs have no effect and `res_hi_o` keeps its previous value.
- R2: Sub-opcode 1 writes the low 32 bits of `src_a_i*src_b_i + acc_lo_i`, wrapping modulo 2^32, to `res_lo_o`. Only `wr_lo_o` is set.
- R3: Sub-opcode 4 forms the 64-bit product of both operands taken as unsigned. Bits 31:0 go to `res_lo_o` and bits 63:32 go to `res_hi_o`, and both write enables are set.
- R4: Sub-opcode 6 forms the 64-bit product of both operands taken as two's-complement. The product is split and written as in R3.
- R5: Sub-opcode 7 writes the unsigned product plus {`acc_hi_i`,`acc_lo_i`}, modulo 2^64, split as in R3.
- R6: Sub-opcodes 2, 3 and 5 set `unsup_o` together with `done_o` on the second rising edge counted from the accepting edge. Both write enables and `flag_upd_o` stay low, and both result words keep their previous values.
- R7: `flag_upd_o` is high with `done_o` exactly when `set_flags_i` was high at acceptance and the sub-opcode is supported. N is bit 63 of the result for sub-opcodes 4, 6 and 7, and bit 31 otherwise. Z is 1 only when every written result bit is zero.
- R8: For a supported sub-opcode, `busy_o` is high from the accepting edge onward. `done_o` is high for exactly one cycle, after the (STEPS+1)-th rising edge following the accepting edge, which is the 18th edge counting the accepting one at the defaults.
- R9: A `start_i` pulse while `busy_o` is high has no effect: the running operation keeps its result and timing, and no second completion follows.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation; accepted only when not busy |
| subop_i | input | 3 | Operation select |
| set_flags_i | input | 1 | Request an N/Z update |
| src_a_i | input | W | First multiplicand |
| src_b_i | input | W | Second multiplicand |
| acc_lo_i | input | W | Low accumulator word |
| acc_hi_i | input | W | High accumulator word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| unsup_o | output | 1 | Completion of an unimplemented sub-opcode |
| wr_lo_o | output | 1 | Write enable for the low result word |
| wr_hi_o | output | 1 | Write enable for the high result word |
| res_lo_o | output | W | Low result word |
| res_hi_o | output | W | High result word |
| flag_upd_o | output | 1 | N and Z are to be written |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
The assertions assume that reset is asserted before any stimulus, that `start_i` and every operand input is 0 or 1 at each bit, and that the core only uses results in the `done_o` cycle. The bench drives all inputs on falling edges and holds `start_i` for exactly one cycle per request. It also sends some requests while the unit is busy, to cover R9. The operands are sampled only at the accepting edge, so the bench may change them freely afterwards, and the latency property counts edges from that point.

// File: rtl/imul_pkg.sv
package imul_pkg;
  localparam int SUBOP_W = 3;

  localparam logic [SUBOP_W-1:0] SUB_MUL   = 3'd0;
  localparam logic [SUBOP_W-1:0] SUB_MLA   = 3'd1;
  localparam logic [SUBOP_W-1:0] SUB_UMULL = 3'd4;
  localparam logic [SUBOP_W-1:0] SUB_SMULL = 3'd6;
  localparam logic [SUBOP_W-1:0] SUB_UMLAL = 3'd7;

  typedef struct packed {
    logic valid;
    logic is_long;
    logic is_signed;
    logic acc_short;
    logic acc_long;
  } op_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WRAP = 2'd2
  } seq_state_t;

  function automatic op_ctl_t decode_op(input logic [SUBOP_W-1:0] code);
    op_ctl_t c;
    c = '0;
    case (code)
      SUB_MUL:   c.valid = 1'b1;
      SUB_MLA:   begin c.valid = 1'b1; c.acc_short = 1'b1; end
      SUB_UMULL: begin c.valid = 1'b1; c.is_long = 1'b1; end
      SUB_SMULL: begin c.valid = 1'b1; c.is_long = 1'b1; c.is_signed = 1'b1; end
      SUB_UMLAL: begin c.valid = 1'b1; c.is_long = 1'b1; c.acc_long = 1'b1; end
      default:   c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/imul_seq.sv
module imul_seq
  import imul_pkg::*;
#(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_valid,
  output logic accept,
  output logic step_en,
  output logic finish,
  output logic busy
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  seq_state_t state_q;
  logic [CW-1:0] cnt_q;

  assign accept  = start && (state_q == ST_IDLE);
  assign step_en = (state_q == ST_RUN);
  assign finish  = (state_q == ST_WRAP);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= op_valid ? ST_RUN : ST_WRAP;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_WRAP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/imul_iter.sv
module imul_iter #(
  parameter int W  = 32,
  parameter int SB = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  output logic [2*W-1:0] prod
);
  logic [W-1:0]      mcand_q, mplier_q;
  logic [2*W-1:0]    prod_q;
  logic [W+SB-1:0]   upper;
  logic [2*W+SB-1:0] joined;

  // multiplicand times one SB-bit digit of the multiplier
  function automatic logic [W+SB-1:0] digit_mult(input logic [W-1:0] m,
                                                 input logic [SB-1:0] d);
    logic [W+SB-1:0] acc;
    acc = '0;
    for (int i = 0; i < SB; i++)
      if (d[i]) acc = acc + ({{SB{1'b0}}, m} << i);
    return acc;
  endfunction

  always_comb begin
    upper  = {{SB{1'b0}}, prod_q[2*W-1:W]} + digit_mult(mcand_q, mplier_q[SB-1:0]);
    joined = {upper, prod_q[W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
    end else if (load) begin
      mcand_q  <= mag_a;
      mplier_q <= mag_b;
      prod_q   <= '0;
    end else if (step) begin
      mplier_q <= mplier_q >> SB;
      prod_q   <= joined[2*W+SB-1:SB];
    end
  end

  assign prod = prod_q;
endmodule

// File: rtl/imul_finish.sv
module imul_finish #(
  parameter int W = 32
) (
  input  logic           is_long,
  input  logic           acc_short,
  input  logic           acc_long,
  input  logic           negate,
  input  logic [2*W-1:0] raw,
  input  logic [W-1:0]   acc_lo,
  input  logic [W-1:0]   acc_hi,
  output logic [W-1:0]   lo,
  output logic [W-1:0]   hi,
  output logic           n,
  output logic           z
);
  logic [2*W-1:0] full;
  logic [W-1:0]   short_sum;

  function automatic logic [2*W-1:0] apply_sign(input logic [2*W-1:0] v, input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [2*W-1:0] add_wide(input logic [2*W-1:0] v,
                                              input logic [W-1:0] h,
                                              input logic [W-1:0] l,
                                              input logic en);
    return en ? (v + {h, l}) : v;
  endfunction

  always_comb begin
    full      = add_wide(apply_sign(raw, negate), acc_hi, acc_lo, acc_long);
    short_sum = raw[W-1:0] + (acc_short ? acc_lo : '0);
    if (is_long) begin
      lo = full[W-1:0];
      hi = full[2*W-1:W];
      n  = full[2*W-1];
      z  = ~|full;
    end else begin
      lo = short_sum;
      hi = '0;
      n  = short_sum[W-1];
      z  = ~|short_sum;
    end
  end
endmodule

// File: rtl/imul_core.sv
module imul_core
  import imul_pkg::*;
#(
  parameter int W         = 32,
  parameter int STEP_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [SUBOP_W-1:0] subop_i,
  input  logic               set_flags_i,
  input  logic [W-1:0]       src_a_i,
  input  logic [W-1:0]       src_b_i,
  input  logic [W-1:0]       acc_lo_i,
  input  logic [W-1:0]       acc_hi_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               unsup_o,
  output logic               wr_lo_o,
  output logic               wr_hi_o,
  output logic [W-1:0]       res_lo_o,
  output logic [W-1:0]       res_hi_o,
  output logic               flag_upd_o,
  output logic               flag_n_o,
  output logic               flag_z_o
);
  localparam int STEPS = W / STEP_BITS;

  // named internal events, also observed by the checker
  logic    accept, step_en, finish, busy;
  op_ctl_t dec;

  logic           valid_q, long_q, accs_q, accl_q, neg_q, sf_q;
  logic [W-1:0]   alo_q, ahi_q;
  logic [W-1:0]   mag_a, mag_b;
  logic [2*W-1:0] raw_prod;
  logic [W-1:0]   fin_lo, fin_hi;
  logic           fin_n, fin_z;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
    return (sgn && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  assign dec   = decode_op(subop_i);
  assign mag_a = magnitude(src_a_i, dec.is_signed);
  assign mag_b = magnitude(src_b_i, dec.is_signed);

  imul_seq #(.STEPS(STEPS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .op_valid (dec.valid),
    .accept   (accept),
    .step_en  (step_en),
    .finish   (finish),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      long_q  <= 1'b0;
      accs_q  <= 1'b0;
      accl_q  <= 1'b0;
      neg_q   <= 1'b0;
      sf_q    <= 1'b0;
      alo_q   <= '0;
      ahi_q   <= '0;
    end else if (accept) begin
      valid_q <= dec.valid;
      long_q  <= dec.is_long;
      accs_q  <= dec.acc_short;
      accl_q  <= dec.acc_long;
      neg_q   <= dec.is_signed && (src_a_i[W-1] ^ src_b_i[W-1]);
      sf_q    <= set_flags_i;
      alo_q   <= acc_lo_i;
      ahi_q   <= acc_hi_i;
    end
  end

  imul_iter #(.W(W), .SB(STEP_BITS)) u_iter (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept && dec.valid),
    .step  (step_en),
    .mag_a (mag_a),
    .mag_b (mag_b),
    .prod  (raw_prod)
  );

  imul_finish #(.W(W)) u_fin (
    .is_long   (long_q),
    .acc_short (accs_q),
    .acc_long  (accl_q),
    .negate    (neg_q),
    .raw       (raw_prod),
    .acc_lo    (alo_q),
    .acc_hi    (ahi_q),
    .lo        (fin_lo),
    .hi        (fin_hi),
    .n         (fin_n),
    .z         (fin_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      unsup_o    <= 1'b0;
      wr_lo_o    <= 1'b0;
      wr_hi_o    <= 1'b0;
      flag_upd_o <= 1'b0;
      res_lo_o   <= '0;
      res_hi_o   <= '0;
      flag_n_o   <= 1'b0;
      flag_z_o   <= 1'b0;
    end else begin
      done_o     <= finish;
      unsup_o    <= finish && !valid_q;
      wr_lo_o    <= finish && valid_q;
      wr_hi_o    <= finish && valid_q && long_q;
      flag_upd_o <= finish && valid_q && sf_q;
      if (finish && valid_q) res_lo_o <= fin_lo;
      if (finish && valid_q && long_q) res_hi_o <= fin_hi;
      if (finish && valid_q && sf_q) begin
        flag_n_o <= fin_n;
        flag_z_o <= fin_z;
      end
    end
  end

  assign busy_o = busy;
endmodule

// File: rtl/imul_core_chk.sv
module imul_core_chk #(
  parameter int W     = 32,
  parameter int STEPS = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         busy_o,
  input logic         start_i,
  input logic         done_o,
  input logic         unsup_o,
  input logic         wr_lo_o,
  input logic         wr_hi_o,
  input logic         flag_upd_o,
  input logic         flag_n_o,
  input logic         flag_z_o,
  input logic [W-1:0] res_lo_o,
  input logic [W-1:0] res_hi_o
);
  localparam int LW = $clog2(STEPS + 4) + 1;
  logic [LW-1:0] lat_q;

  // edges since acceptance, the accepting edge counting as one
  always_ff @(posedge clk) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= LW'(1);
    else if (busy_o) lat_q <= lat_q + 1'b1;
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !unsup_o) |-> (lat_q == LW'(STEPS + 2)));
  p_unsup_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && unsup_o) |-> (lat_q == LW'(2)));
  p_unsup_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> (!wr_lo_o && !wr_hi_o && !flag_upd_o));
  p_write_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_o || wr_hi_o || flag_upd_o) |-> done_o);
  p_long_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_o |-> wr_lo_o);
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));
  p_flag_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd_o && wr_hi_o) |->
      (flag_n_o == res_hi_o[W-1]) && (flag_z_o == ((res_hi_o == '0) && (res_lo_o == '0))));
  p_flag_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd_o && !wr_hi_o) |->
      (flag_n_o == res_lo_o[W-1]) && (flag_z_o == (res_lo_o == '0)));
endmodule

bind imul_core imul_core_chk #(.W(W), .STEPS(STEPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .busy_o     (busy_o),
  .start_i    (start_i),
  .done_o     (done_o),
  .unsup_o    (unsup_o),
  .wr_lo_o    (wr_lo_o),
  .wr_hi_o    (wr_hi_o),
  .flag_upd_o (flag_upd_o),
  .flag_n_o   (flag_n_o),
  .flag_z_o   (flag_z_o),
  .res_lo_o   (res_lo_o),
  .res_hi_o   (res_hi_o)
);

// File: tb/imul_core_test.sv
`timescale 1ns/1ps
module imul_core_test;
  localparam int NV      = 13;
  localparam int LAT_OK  = 18;
  localparam int LAT_BAD = 2;

  localparam logic [2:0]  T_OP  [NV] = '{3'd0, 3'd0, 3'd1, 3'd4, 3'd4, 3'd6, 3'd6,
                                         3'd6, 3'd7, 3'd7, 3'd2, 3'd3, 3'd5};
  localparam logic [31:0] T_A   [NV] = '{32'd7, 32'h10000, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                         32'h10000, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFD,
                                         32'hFFFFFFFF, 32'd0, 32'd3, 32'd4, 32'd5};
  localparam logic [31:0] T_B   [NV] = '{32'd6, 32'h10000, 32'd2, 32'hFFFFFFFF,
                                         32'h10000, 32'h80000000, 32'd1, 32'd5,
                                         32'hFFFFFFFF, 32'h1234, 32'd3, 32'd4, 32'd5};
  localparam logic [31:0] T_ALO [NV] = '{32'h1234, 32'd0, 32'd5, 32'd9, 32'd0, 32'd0, 32'd0,
                                         32'd0, 32'hFFFFFFFF, 32'd0, 32'd1, 32'd1, 32'd1};
  localparam logic [31:0] T_AHI [NV] = '{32'h55, 32'd0, 32'd7, 32'd9, 32'd0, 32'd0, 32'd0,
                                         32'd0, 32'hFFFFFFFF, 32'd0, 32'd1, 32'd1, 32'd1};
  localparam logic        T_SF  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1,
                                         1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

  logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, set_flags_i = 1'b0;
  logic [2:0]  subop_i = '0;
  logic [31:0] src_a_i = '0, src_b_i = '0, acc_lo_i = '0, acc_hi_i = '0;
  logic        busy_o, done_o, unsup_o, wr_lo_o, wr_hi_o, flag_upd_o, flag_n_o, flag_z_o;
  logic [31:0] res_lo_o, res_hi_o;

  int checks = 0, errors = 0, cycles = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  imul_core uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      wrap_up();
    end
  end

  // independent arithmetic restatement of R1..R6
  task automatic model(input logic [2:0] op, input logic [31:0] a, b, alo, ahi,
                       output logic [63:0] r, output logic un, output logic lg);
    longint unsigned ua, ub;
    ua = {32'd0, a}; ub = {32'd0, b};
    un = 1'b0; lg = 1'b0; r = '0;
    case (op)
      3'd0: r = {32'd0, 32'(ua * ub)};
      3'd1: r = {32'd0, 32'(ua * ub + {32'd0, alo})};
      3'd4: begin r = ua * ub; lg = 1'b1; end
      3'd6: begin r = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b})); lg = 1'b1; end
      3'd7: begin r = ua * ub + {ahi, alo}; lg = 1'b1; end
      default: un = 1'b1;
    endcase
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] a, b, alo, ahi,
                        input logic sf, input string req);
    logic [63:0] r; logic un, lg; logic [31:0] plo, phi; int cyc;
    model(op, a, b, alo, ahi, r, un, lg);
    plo = res_lo_o; phi = res_hi_o;
    @(negedge clk);
    subop_i = op; src_a_i = a; src_b_i = b; acc_lo_i = alo; acc_hi_i = ahi;
    set_flags_i = sf; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; src_a_i = ~a; src_b_i = ~b; acc_lo_i = ~alo; acc_hi_i = ~ahi;
    cyc = 1;
    while (!done_o && cyc < 100) begin @(negedge clk); cyc++; end
    chk({req, " R8 latency"}, 64'(cyc), un ? 64'(LAT_BAD) : 64'(LAT_OK));
    chk({req, " R6 unsup"}, {63'd0, unsup_o}, {63'd0, un});
    chk({req, " wr_lo"}, {63'd0, wr_lo_o}, {63'd0, !un});
    chk({req, " wr_hi"}, {63'd0, wr_hi_o}, {63'd0, lg});
    chk({req, " low word"}, {32'd0, res_lo_o}, un ? {32'd0, plo} : {32'd0, r[31:0]});
    chk({req, " high word"}, {32'd0, res_hi_o}, lg ? {32'd0, r[63:32]} : {32'd0, phi});
    chk({req, " R7 flag_upd"}, {63'd0, flag_upd_o}, {63'd0, sf && !un});
    if (sf && !un) begin
      chk({req, " R7 N"}, {63'd0, flag_n_o}, {63'd0, lg ? r[63] : r[31]});
      chk({req, " R7 Z"}, {63'd0, flag_z_o}, {63'd0, lg ? (r == 64'd0) : (r[31:0] == 32'd0)});
    end
    @(negedge clk);
    chk({req, " R8 one-cycle done"}, {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 outputs in reset",
        {busy_o, done_o, unsup_o, wr_lo_o, wr_hi_o, flag_upd_o, flag_n_o, flag_z_o,
         |res_lo_o, |res_hi_o}, 64'd0);
    rst_n = 1'b1;

    // table walk: vectors exercise R1..R7
    for (int i = 0; i < NV; i++) begin
      string tag;
      case (T_OP[i])
        3'd0: tag = "R1"; 3'd1: tag = "R2"; 3'd4: tag = "R3";
        3'd6: tag = "R4"; 3'd7: tag = "R5"; default: tag = "R6";
      endcase
      run_op(T_OP[i], T_A[i], T_B[i], T_ALO[i], T_AHI[i], T_SF[i], tag);
    end

    // R8: busy right after acceptance
    @(negedge clk);
    subop_i = 3'd4; src_a_i = 32'd2; src_b_i = 32'd3; start_i = 1'b1; set_flags_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 busy after accept", {63'd0, busy_o}, 64'd1);
    while (!done_o) @(negedge clk);
    chk("R3 small product", {res_hi_o, res_lo_o}, 64'd6);

    // R9: start while busy is ignored
    begin
      int cyc; int extra;
      @(negedge clk);
      subop_i = 3'd4; src_a_i = 32'd3; src_b_i = 32'd5; acc_lo_i = 32'd0; acc_hi_i = 32'd0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; cyc = 1;
      repeat (4) begin @(negedge clk); cyc++; end
      subop_i = 3'd0; src_a_i = 32'd9; src_b_i = 32'd9; start_i = 1'b1;
      @(negedge clk); cyc++;
      start_i = 1'b0;
      while (!done_o && cyc < 100) begin @(negedge clk); cyc++; end
      chk("R9 latency unchanged", 64'(cyc), 64'(LAT_OK));
      chk("R9 result of first op", {res_hi_o, res_lo_o}, 64'd15);
      chk("R9 long write kept", {63'd0, wr_hi_o}, 64'd1);
      extra = 0;
      repeat (30) begin @(negedge clk); if (done_o) extra++; end
      chk("R9 no second completion", 64'(extra), 64'd0);
    end

    // R1: short multiply leaves the high word untouched after a long one
    run_op(3'd4, 32'hDEADBEEF, 32'h12345678, 32'd0, 32'd0, 1'b1, "R3");
    run_op(3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hAAAA, 32'hBBBB, 1'b1, "R1");
    run_op(3'd1, 32'h80000000, 32'd2, 32'h80000000, 32'd0, 1'b1, "R2");

    wrap_up();
  end
endmodule